// File: doc/BRIEF.md
# Base-and-Bound Address Guard

This unit sits on the path from a processor's logical address output to physical memory. When a request comes from user mode, the unit compares the logical address with a per-process bound register. If the address is in range, the unit adds a relocation offset to it and issues the physical address. If the address is out of range, the unit raises a fault, and no address goes out to memory. A request from kernel mode skips both the bound check and the relocation: its address goes to memory unchanged, so the kernel can reach all of physical memory.

The two registers can be loaded only through a separate write port, and only when that port is driven in kernel mode. A write attempted in user mode is refused and reported as a privilege fault. A process is moved in memory (for example, during compaction) by loading a new relocation offset. The program's logical addresses stay the same and the bound register is not touched. Every response comes out one clock cycle after its request.

Top module: `reloc_guard`

## Requirements
- R1: After reset both the relocation offset and the bound are zero, and all outputs are low. Every user-mode request therefore faults until the kernel loads a bound.
- R2: A user-mode request whose logical address is below the bound produces, in the next cycle, rspValid high and rspAddr equal to the logical address plus the relocation offset, modulo 2^ADDR_W.
- R3: A user-mode request whose logical address is greater than or equal to the bound produces, in the next cycle, rspFault high and rspValid low. An address exactly equal to the bound faults.
- R4: A kernel-mode request produces, in the next cycle, rspValid high and rspAddr equal to the logical address unchanged, whatever the bound and offset are.
- R5: A kernel-mode write loads the relocation offset when wrSel is 0 and the bound when wrSel is 1. The new value applies to requests from the following cycle on. A request in the same cycle as the write still sees the old value.
- R6: A user-mode write raises wrFault in the next cycle and leaves both registers unchanged.
- R7: rspValid and rspFault are never both high. A cycle without a request produces neither in the next cycle, and rspAddr is zero whenever rspValid is low.
- R8: Reloading only the relocation offset moves the physical addresses of later user requests by the new offset. The bound and the logical addresses stay the same.
- R9: A kernel-mode write never raises wrFault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqKernel | input | 1 | Request issued in kernel mode |
| reqAddr | input | ADDR_W | Logical address |
| wrValid | input | 1 | Register write present |
| wrKernel | input | 1 | Write issued in kernel mode |
| wrSel | input | 1 | 0 selects relocation offset, 1 selects bound |
| wrData | input | ADDR_W | Value to load |
| rspValid | output | 1 | Physical address issued |
| rspAddr | output | ADDR_W | Physical address |
| rspFault | output | 1 | Bound violation, no memory access |
| wrFault | output | 1 | Privilege violation on a register write |

## Verification
The bench builds the unit with ADDR_W set to 8. At that width an offset near the top of the space makes the relocation sum wrap past 2^8, and a bound of the largest encodable value can be loaded. The bench checks that the wrap is modular and that the in-range/out-of-range boundary sits exactly at the bound. A small width also lets a kernel address far above the bound show that kernel requests skip the check.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef struct packed {
    logic loadBase;
    logic loadLimit;
    logic grant;
    logic bypass;
    logic rangeFault;
    logic privFault;
  } relocStrobes_t;
endpackage

// File: rtl/reloc_ctrl.sv
module reloc_ctrl
  import reloc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqKernel,
  input  logic          wrValid,
  input  logic          wrKernel,
  input  logic          wrSel,
  input  logic          inRange,
  output relocStrobes_t strobes,
  output logic          rspValid,
  output logic          rspFault,
  output logic          wrFault
);
  always_comb begin
    strobes            = '0;
    strobes.loadBase   = wrValid && wrKernel && !wrSel;
    strobes.loadLimit  = wrValid && wrKernel && wrSel;
    strobes.privFault  = wrValid && !wrKernel;
    strobes.bypass     = reqValid && reqKernel;
    strobes.grant      = reqValid && !reqKernel && inRange;
    strobes.rangeFault = reqValid && !reqKernel && !inRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      wrFault  <= 1'b0;
    end else begin
      rspValid <= strobes.grant || strobes.bypass;
      rspFault <= strobes.rangeFault;
      wrFault  <= strobes.privFault;
    end
  end
endmodule

// File: rtl/reloc_datapath.sv
module reloc_datapath
  import reloc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  relocStrobes_t     strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] wrData,
  output logic              inRange,
  output logic [ADDR_W-1:0] rspAddr
);
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] limitReg;
  logic [ADDR_W-1:0] relocSum;

  assign inRange  = reqAddr < limitReg;
  assign relocSum = reqAddr + baseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      limitReg <= '0;
    end else begin
      if (strobes.loadBase)  baseReg  <= wrData;
      if (strobes.loadLimit) limitReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rspAddr <= '0;
    else if (strobes.bypass) rspAddr <= reqAddr;
    else if (strobes.grant)  rspAddr <= relocSum;
    else                     rspAddr <= '0;
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqKernel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrValid,
  input  logic              wrKernel,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] wrData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspFault,
  output logic              wrFault
);
  relocStrobes_t strobes;
  logic          inRange;

  reloc_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKernel(reqKernel),
    .wrValid(wrValid), .wrKernel(wrKernel), .wrSel(wrSel), .inRange(inRange),
    .strobes(strobes), .rspValid(rspValid), .rspFault(rspFault), .wrFault(wrFault)
  );

  reloc_datapath #(.ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .wrData(wrData), .inRange(inRange), .rspAddr(rspAddr)
  );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqKernel,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              wrValid,
  input logic              wrKernel,
  input logic              wrSel,
  input logic [ADDR_W-1:0] wrData,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              rspFault,
  input logic              wrFault
);
  logic [ADDR_W-1:0] shBase, shLimit, expAddr;
  logic prevUserOk, prevUserBad, prevKernel, prevIdle, prevUserWr, prevKernWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shBase <= '0; shLimit <= '0; expAddr <= '0;
      prevUserOk <= 1'b0; prevUserBad <= 1'b0; prevKernel <= 1'b0;
      prevIdle <= 1'b0; prevUserWr <= 1'b0; prevKernWr <= 1'b0;
    end else begin
      if (wrValid && wrKernel && !wrSel) shBase  <= wrData;
      if (wrValid && wrKernel && wrSel)  shLimit <= wrData;
      prevUserOk  <= reqValid && !reqKernel && (reqAddr < shLimit);
      prevUserBad <= reqValid && !reqKernel && (reqAddr >= shLimit);
      prevKernel  <= reqValid && reqKernel;
      prevIdle    <= !reqValid;
      prevUserWr  <= wrValid && !wrKernel;
      prevKernWr  <= wrValid && wrKernel;
      expAddr     <= reqKernel ? reqAddr : reqAddr + shBase;
    end
  end

  a_r2_translate: assert property (@(posedge clk) disable iff (!rstN)
    prevUserOk |-> (rspValid && rspAddr == expAddr));
  a_r3_bound_fault: assert property (@(posedge clk) disable iff (!rstN)
    prevUserBad |-> (rspFault && !rspValid));
  a_r4_kernel_pass: assert property (@(posedge clk) disable iff (!rstN)
    prevKernel |-> (rspValid && rspAddr == expAddr));
  a_r6_priv_fault: assert property (@(posedge clk) disable iff (!rstN)
    prevUserWr |-> wrFault);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && rspFault));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    prevIdle |-> (!rspValid && !rspFault && rspAddr == '0));
  a_r9_kernel_write_ok: assert property (@(posedge clk) disable iff (!rstN)
    (prevKernWr && !prevUserWr) |-> !wrFault);
endmodule

bind reloc_guard reloc_guard_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKernel(reqKernel),
  .reqAddr(reqAddr), .wrValid(wrValid), .wrKernel(wrKernel), .wrSel(wrSel),
  .wrData(wrData), .rspValid(rspValid), .rspAddr(rspAddr),
  .rspFault(rspFault), .wrFault(wrFault)
);

// File: tb/reloc_guard_test.sv
module reloc_guard_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqKernel = 1'b0, wrValid = 1'b0, wrKernel = 1'b0, wrSel = 1'b0;
  logic [W-1:0] reqAddr = '0, wrData = '0;
  logic rspValid, rspFault, wrFault;
  logic [W-1:0] rspAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic         v;
    logic         f;
    logic         wf;
    logic [W-1:0] a;
    string        tag;
  } expItem_t;

  expItem_t q[$];
  logic [W-1:0] mBase = '0, mLimit = '0;

  always #5 clk = ~clk;

  reloc_guard #(.ADDR_W(W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKernel(reqKernel),
    .reqAddr(reqAddr), .wrValid(wrValid), .wrKernel(wrKernel), .wrSel(wrSel),
    .wrData(wrData), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspFault(rspFault), .wrFault(wrFault)
  );

  task automatic step(input logic rv, input logic rk, input logic [W-1:0] ra,
                      input logic wv, input logic wk, input logic ws,
                      input logic [W-1:0] wd, input string tag);
    expItem_t e;
    @(negedge clk);
    reqValid = rv; reqKernel = rk; reqAddr = ra;
    wrValid = wv; wrKernel = wk; wrSel = ws; wrData = wd;
    e.tag = tag;
    e.wf  = wv && !wk;
    if (rv && rk)                begin e.v = 1; e.f = 0; e.a = ra; end
    else if (rv && (ra < mLimit)) begin e.v = 1; e.f = 0; e.a = ra + mBase; end
    else if (rv)                 begin e.v = 0; e.f = 1; e.a = '0; end
    else                         begin e.v = 0; e.f = 0; e.a = '0; end
    q.push_back(e);
    if (wv && wk) begin
      if (ws) mLimit = wd; else mBase = wd;
    end
  endtask

  task automatic userReq(input logic [W-1:0] a, input string tag);
    step(1, 0, a, 0, 0, 0, '0, tag);
  endtask

  task automatic kernReq(input logic [W-1:0] a, input string tag);
    step(1, 1, a, 0, 0, 0, '0, tag);
  endtask

  task automatic regWrite(input logic k, input logic sel, input logic [W-1:0] d, input string tag);
    step(0, 0, '0, 1, k, sel, d, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      checks++;
      if (rspValid !== e.v || rspFault !== e.f || wrFault !== e.wf || rspAddr !== e.a) begin
        fails++;
        $display("FAIL %s: got v=%0b f=%0b wf=%0b a=%02h, expected v=%0b f=%0b wf=%0b a=%02h",
                 e.tag, rspValid, rspFault, wrFault, rspAddr, e.v, e.f, e.wf, e.a);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 0 || rspFault !== 0 || wrFault !== 0 || rspAddr !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs: got v=%0b f=%0b wf=%0b a=%02h, expected all zero",
               rspValid, rspFault, wrFault, rspAddr);
    end
    rstN = 1'b1;
    userReq(8'h00, "R1 zero bound faults");
    kernReq(8'h5A, "R4 kernel passthrough");
    regWrite(1, 0, 8'h40, "R5 R9 load offset");
    step(1, 0, 8'h10, 1, 1, 1, 8'h20, "R5 same-cycle request sees old bound");
    userReq(8'h10, "R2 translate low");
    userReq(8'h1F, "R2 translate last in range");
    userReq(8'h20, "R3 address equal to bound");
    userReq(8'hFF, "R3 far above bound");
    kernReq(8'hF0, "R4 kernel above bound");
    regWrite(0, 0, 8'h00, "R6 user write offset refused");
    userReq(8'h10, "R6 offset unchanged");
    regWrite(0, 1, 8'hFF, "R6 user write bound refused");
    userReq(8'h20, "R6 bound unchanged");
    regWrite(1, 0, 8'h10, "R8 compaction reload offset");
    userReq(8'h10, "R8 moved address");
    userReq(8'h20, "R8 bound kept");
    regWrite(1, 0, 8'hF0, "R5 offset near top");
    regWrite(1, 1, 8'h30, "R5 new bound");
    userReq(8'h20, "R2 modular wrap");
    regWrite(1, 1, 8'hFF, "R5 maximum bound");
    userReq(8'hFE, "R2 highest in-range address");
    userReq(8'hFF, "R3 top address equals bound");
    step(0, 0, '0, 0, 0, 0, '0, "R7 idle cycle quiet");
    step(0, 0, '0, 0, 0, 0, '0, "R7 idle cycle quiet again");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule